// File: doc/BRIEF.md
# Tower Pair Energy Decompressor

This block turns the two compressed 8-bit energy codes of one electromagnetic/hadronic tower pair into linear 16-bit energies. It adds them into a 17-bit pair sum and raises an electron-candidate flag when the hadronic share is small enough. The conversion is not a stored table. It is one of two run-time selectable functions. The first is a mantissa/exponent shift. The second is a four-segment piecewise-linear curve that uses one multiply and one add per tower.

Every function coefficient and the cut ratio are held in writable registers. A narrow write port loads a staging copy. An apply strobe then moves the whole staging copy into the working set in one edge, so parameters can be changed while data flows and no input is ever converted with a half-updated set. Results leave through a fixed three-stage pipeline with a valid strobe.

Top module: `tower_decomp`

## Requirements
- R1: An input sampled with `in_vld` high on rising edge t yields `out_vld` high with its results after edge t+2, with one stage per edge and back-to-back inputs accepted. `out_vld` is low in every other cycle.
- R2: In shift mode each code splits into exponent bits [7:5] and mantissa bits [4:0]. The linear energy is the mantissa shifted left by the exponent, saturated at 65535.
- R3: In segment mode the segment for a code c is chosen from the tower's three knees k0, k1, k2. Segment 0 applies when c < k0, segment 1 when k0 ≤ c < k1, segment 2 when k1 ≤ c < k2, and segment 3 otherwise. The segment start is 0, k0, k1 or k2 respectively.
- R4: In segment mode the energy is base[s] + floor(slope[s]·(c − start)/16), saturated at 65535. The slope is an unsigned 8-bit value with 4 fraction bits.
- R5: `out_sum` equals `out_em` + `out_had` in 17 bits, with no loss.
- R6: `out_ele` is 1 exactly when `in_fg` was 0 and 8·hadronic ≤ ratio·electromagnetic, using the 3-bit ratio.
- R7: Writes go to a staging set and have no effect on results until `cfg_apply`. Apply copies the whole set in one edge. An input sampled on the same edge as the apply is converted with the new set.
- R8: Register map. `cfg_addr[4]` selects the tower (0 electromagnetic, 1 hadronic). Low nibble 0–2 holds knees k0–k2 in data[7:0], 3–6 holds slopes of segments 0–3 in data[7:0], and 7–10 holds bases of segments 0–3 in data[15:0].
- R9: Address 0x0F is the mode word. Bit 0 selects the conversion (0 shift, 1 segment) and bits [3:1] hold the ratio.
- R10: Writes to low nibbles 11–14 and to address 0x1F change nothing.
- R11: Reset clears all outputs and both parameter sets (shift mode, ratio 0, all coefficients 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input pair valid |
| in_em_code | input | 8 | Compressed electromagnetic code |
| in_had_code | input | 8 | Compressed hadronic code |
| in_fg | input | 1 | Fine-grain veto flag |
| cfg_wr | input | 1 | Staging register write enable |
| cfg_addr | input | 5 | Staging register address |
| cfg_wdata | input | 16 | Staging register write data |
| cfg_apply | input | 1 | Copy staging set to working set |
| out_vld | output | 1 | Result valid |
| out_em | output | 16 | Linear electromagnetic energy |
| out_had | output | 16 | Linear hadronic energy |
| out_sum | output | 17 | Pair energy sum |
| out_ele | output | 1 | Electron-candidate flag |

## Verification
Several properties are checked on every clock. The valid strobe trails the first stage by exactly two edges. The working set moves only on an apply. A fine-grain veto always clears the electron flag, and zero hadronic energy with no veto always sets it. A shift-mode result keeps the mantissa's set-bit count. A segment-mode code below the first knee never lands under its base. The directed scenarios carry the arithmetic against an independent model: segment edges at each knee, saturation, the cut at equality, isolation of staged writes, an apply that coincides with an input, and the ignored addresses.

// File: rtl/td_pkg.sv
package td_pkg;
   localparam int unsigned TD_CODE_W  = 8;
   localparam int unsigned TD_EN_W    = 16;
   localparam int unsigned TD_NSEG    = 4;
   localparam int unsigned TD_SLOPE_W = 8;
   localparam int unsigned TD_RATIO_W = 3;

   typedef enum logic {CVT_SHIFT = 1'b0, CVT_SEGMENT = 1'b1} cvt_mode_e;

   typedef struct packed {
      logic [TD_NSEG-2:0][TD_CODE_W-1:0]  knee;
      logic [TD_NSEG-1:0][TD_SLOPE_W-1:0] slope;
      logic [TD_NSEG-1:0][TD_EN_W-1:0]    base;
   } seg_cfg_t;

   typedef struct packed {
      cvt_mode_e             mode;
      logic [TD_RATIO_W-1:0] ratio;
      seg_cfg_t [1:0]        twr;
   } td_cfg_t;
endpackage

// File: rtl/td_cfg_regs.sv
module td_cfg_regs
   import td_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              apply,
   output td_cfg_t           act
);
   localparam int unsigned IDX_KNEE  = 0;
   localparam int unsigned IDX_SLOPE = TD_NSEG - 1;
   localparam int unsigned IDX_BASE  = IDX_SLOPE + TD_NSEG;
   localparam int unsigned IDX_END   = IDX_BASE + TD_NSEG;
   localparam logic [3:0]  IDX_MODE  = 4'hF;

   if (ADDR_W != 5) begin : g_bad_addr
      $error("td_cfg_regs: map needs a 5-bit address");
   end
   if (DATA_W < TD_EN_W) begin : g_bad_data
      $error("td_cfg_regs: data narrower than base field");
   end

   td_cfg_t    stg;
   logic [3:0] idx;
   logic       tsel;

   assign idx  = addr[3:0];
   assign tsel = addr[4];

   // R8 R9 R10: staging writes
   always_ff @(posedge clk) begin
      if (rst) begin
         stg <= '0;
      end else if (wr) begin
         if (idx == IDX_MODE) begin
            if (!tsel) begin
               stg.mode  <= cvt_mode_e'(wdata[0]);
               stg.ratio <= wdata[TD_RATIO_W:1];
            end
         end else if (32'(idx) < IDX_SLOPE) begin
            stg.twr[tsel].knee[2'(idx)] <= wdata[TD_CODE_W-1:0];
         end else if (32'(idx) < IDX_BASE) begin
            stg.twr[tsel].slope[2'(idx - 4'(IDX_SLOPE))] <= wdata[TD_SLOPE_W-1:0];
         end else if (32'(idx) < IDX_END) begin
            stg.twr[tsel].base[2'(idx - 4'(IDX_BASE))] <= wdata[TD_EN_W-1:0];
         end
      end
   end

   // R7: whole-set copy on apply
   always_ff @(posedge clk) begin
      if (rst)        act <= '0;
      else if (apply) act <= stg;
   end

   p_act_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !apply |=> $stable(act));
endmodule

// File: rtl/td_convert.sv
module td_convert
   import td_pkg::*;
#(
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned EN_W    = 16,
   parameter int unsigned SLOPE_W = 8,
   parameter int unsigned FRAC_W  = 4,
   parameter bit          SEG_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  cvt_mode_e       mode,
   input  logic [CODE_W-1:0] code,
   input  seg_cfg_t        cfg,
   output logic [EN_W-1:0] lin_q
);
   localparam int unsigned MANT_W = CODE_W - EXP_W;
   localparam int unsigned ME_W   = MANT_W + (2**EXP_W) - 1;
   localparam int unsigned PROD_W = SLOPE_W + CODE_W;
   localparam int unsigned WW     = EN_W + PROD_W + ME_W + 1;
   localparam int unsigned SEG_W  = $clog2(TD_NSEG);
   localparam logic [EN_W-1:0] EN_MAX = '1;

   if (EXP_W == 0 || EXP_W >= CODE_W) begin : g_bad_exp
      $error("td_convert: exponent width out of range");
   end
   if (FRAC_W > SLOPE_W) begin : g_bad_frac
      $error("td_convert: fraction wider than slope");
   end

   logic [WW-1:0]   me_ext;
   logic [EN_W-1:0] me_sat;
   logic [EN_W-1:0] seg_sat;

   // R2: mantissa shifted by exponent, saturated
   always_comb begin
      me_ext = WW'(code[MANT_W-1:0]) << code[CODE_W-1:MANT_W];
      me_sat = (me_ext > WW'(EN_MAX)) ? EN_MAX : me_ext[EN_W-1:0];
   end

   if (SEG_EN) begin : g_seg
      logic [SEG_W-1:0]  seg;
      logic [CODE_W-1:0] start;
      logic [CODE_W-1:0] diff;
      logic [PROD_W-1:0] prod;
      logic [WW-1:0]     seg_ext;

      // R3: first knee above the code picks the segment
      always_comb begin
         seg = SEG_W'(TD_NSEG - 1);
         for (int s = TD_NSEG - 2; s >= 0; s--) begin
            if (code < cfg.knee[s]) seg = SEG_W'(s);
         end
         start = '0;
         for (int s = 1; s < TD_NSEG; s++) begin
            if (seg == SEG_W'(s)) start = cfg.knee[s-1];
         end
         diff    = code - start;
         // R4: one multiply, one add, saturate
         prod    = {{CODE_W{1'b0}}, cfg.slope[seg]} * {{SLOPE_W{1'b0}}, diff};
         seg_ext = WW'(cfg.base[seg]) + WW'(prod >> FRAC_W);
         seg_sat = (seg_ext > WW'(EN_MAX)) ? EN_MAX : seg_ext[EN_W-1:0];
      end

      p_seg_floor_r3: assert property (@(posedge clk) disable iff (rst)
         $past(en && mode == CVT_SEGMENT && code < cfg.knee[0])
            |-> lin_q >= $past(cfg.base[0]));
   end else begin : g_noseg
      assign seg_sat = me_sat;
   end

   always_ff @(posedge clk) begin
      if (rst)     lin_q <= '0;
      else if (en) lin_q <= (mode == CVT_SEGMENT) ? seg_sat : me_sat;
   end

   p_shift_bits_r2: assert property (@(posedge clk) disable iff (rst)
      $past(en && mode == CVT_SHIFT)
         |-> ($countones(lin_q) == $countones($past(code[MANT_W-1:0]))) || (&lin_q));
endmodule

// File: rtl/td_cut.sv
module td_cut #(
   parameter int unsigned EN_W    = 16,
   parameter int unsigned RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               fg,
   input  logic [RATIO_W-1:0] ratio,
   input  logic [EN_W-1:0]    em,
   input  logic [EN_W-1:0]    had,
   output logic               ele_q
);
   localparam int unsigned PW = EN_W + RATIO_W;

   logic [PW-1:0] had_scaled;
   logic [PW-1:0] em_scaled;

   // R6: 8*had <= ratio*em, divisor fixed by ratio width
   always_comb begin
      had_scaled = PW'(had) << RATIO_W;
      em_scaled  = {{RATIO_W{1'b0}}, em} * {{EN_W{1'b0}}, ratio};
   end

   always_ff @(posedge clk) begin
      if (rst)     ele_q <= 1'b0;
      else if (en) ele_q <= !fg && (had_scaled <= em_scaled);
   end

   p_fg_veto_r6: assert property (@(posedge clk) disable iff (rst)
      $past(en && fg) |-> !ele_q);
   p_zero_had_r6: assert property (@(posedge clk) disable iff (rst)
      $past(en && !fg && had == '0) |-> ele_q);
endmodule

// File: rtl/tower_decomp.sv
module tower_decomp
   import td_pkg::*;
#(
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned EN_W    = 16,
   parameter int unsigned SLOPE_W = 8,
   parameter int unsigned FRAC_W  = 4,
   parameter int unsigned RATIO_W = 3,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 16,
   parameter bit          SEG_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [CODE_W-1:0] in_em_code,
   input  logic [CODE_W-1:0] in_had_code,
   input  logic              in_fg,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_apply,
   output logic              out_vld,
   output logic [EN_W-1:0]   out_em,
   output logic [EN_W-1:0]   out_had,
   output logic [EN_W:0]     out_sum,
   output logic              out_ele
);
   localparam int unsigned NTWR  = 2;
   localparam int unsigned SUM_W = EN_W + 1;

   if (CODE_W != TD_CODE_W || EN_W != TD_EN_W || SLOPE_W != TD_SLOPE_W
       || RATIO_W != TD_RATIO_W) begin : g_bad_pkg
      $error("tower_decomp: widths disagree with td_pkg");
   end

   td_cfg_t act;

   td_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .apply(cfg_apply), .act(act)
   );

   // stage 1: capture inputs
   logic                          s1_vld, s1_fg;
   logic [NTWR-1:0][CODE_W-1:0]   s1_code;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld  <= 1'b0;
         s1_fg   <= 1'b0;
         s1_code <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_fg   <= in_fg;
            s1_code <= {in_had_code, in_em_code};
         end
      end
   end

   // stage 2: per-tower conversion, working set read once per input
   logic [NTWR-1:0][EN_W-1:0] s2_lin;
   logic                      s2_vld, s2_fg;
   logic [RATIO_W-1:0]        s2_ratio;

   for (genvar t = 0; t < NTWR; t++) begin : g_twr
      td_convert #(
         .CODE_W(CODE_W), .EXP_W(EXP_W), .EN_W(EN_W),
         .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W), .SEG_EN(SEG_EN)
      ) u_cvt (
         .clk(clk), .rst(rst), .en(s1_vld), .mode(act.mode),
         .code(s1_code[t]), .cfg(act.twr[t]), .lin_q(s2_lin[t])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_vld   <= 1'b0;
         s2_fg    <= 1'b0;
         s2_ratio <= '0;
      end else begin
         s2_vld <= s1_vld;
         if (s1_vld) begin
            s2_fg    <= s1_fg;
            s2_ratio <= act.ratio;
         end
      end
   end

   // stage 3: sum and cut
   td_cut #(.EN_W(EN_W), .RATIO_W(RATIO_W)) u_cut (
      .clk(clk), .rst(rst), .en(s2_vld), .fg(s2_fg), .ratio(s2_ratio),
      .em(s2_lin[0]), .had(s2_lin[1]), .ele_q(out_ele)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         out_em  <= '0;
         out_had <= '0;
         out_sum <= '0;
      end else begin
         out_vld <= s2_vld;
         if (s2_vld) begin
            out_em  <= s2_lin[0];
            out_had <= s2_lin[1];
            out_sum <= SUM_W'(s2_lin[0]) + SUM_W'(s2_lin[1]);   // R5
         end
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (rst)
      out_vld == $past(s1_vld, 2));
endmodule

// File: tb/tower_decomp_tb_top.sv
module tower_decomp_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [7:0]  in_em_code, in_had_code;
   logic        in_fg;
   logic        cfg_wr;
   logic [4:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic        cfg_apply;
   logic        out_vld;
   logic [15:0] out_em, out_had;
   logic [16:0] out_sum;
   logic        out_ele;

   always #2.5 clk = ~clk;

   tower_decomp dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_em_code(in_em_code),
      .in_had_code(in_had_code), .in_fg(in_fg), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply),
      .out_vld(out_vld), .out_em(out_em), .out_had(out_had),
      .out_sum(out_sum), .out_ele(out_ele)
   );

   int n_chk = 0, n_bad = 0;

   // model: working set (w_*) and staging set (g_*)
   int w_knee[2][3], w_slope[2][4], w_base[2][4], w_seg, w_ratio;
   int g_knee[2][3], g_slope[2][4], g_base[2][4], g_seg, g_ratio;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_lin(int t, int c);
      int s, st, v;
      if (w_seg == 0) begin
         v = (c & 31) << (c >> 5);                      // R2
      end else begin
         s = 3;                                          // R3
         if (c < w_knee[t][2]) s = 2;
         if (c < w_knee[t][1]) s = 1;
         if (c < w_knee[t][0]) s = 0;
         st = (s == 0) ? 0 : w_knee[t][s-1];
         v = w_base[t][s] + (w_slope[t][s] * (c - st)) / 16;   // R4
      end
      if (v > 65535) v = 65535;
      return v;
   endfunction

   function automatic int ref_ele(int em, int had, int fg);
      return (fg == 0 && 8 * had <= w_ratio * em) ? 1 : 0;
   endfunction

   task automatic model_apply();
      w_knee = g_knee; w_slope = g_slope; w_base = g_base;
      w_seg = g_seg; w_ratio = g_ratio;
   endtask

   task automatic wr(int a, int d);
      int t, i;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
      t = a >> 4; i = a & 15;
      if (a == 15) begin g_seg = d & 1; g_ratio = (d >> 1) & 7; end
      else if (i < 3) g_knee[t][i] = d & 255;
      else if (i < 7) g_slope[t][i-3] = d & 255;
      else if (i < 11) g_base[t][i-7] = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic apply();
      @(negedge clk);
      cfg_apply = 1'b1;
      model_apply();
      @(negedge clk);
      cfg_apply = 1'b0;
   endtask

   // one isolated input; ap raises apply on the same edge (R7)
   task automatic send(int em, int had, int fg, bit ap, string tag);
      int e_em, e_had;
      @(negedge clk);
      if (ap) begin cfg_apply = 1'b1; model_apply(); end
      in_vld = 1'b1; in_em_code = 8'(em); in_had_code = 8'(had); in_fg = fg[0];
      e_em = ref_lin(0, em); e_had = ref_lin(1, had);
      @(negedge clk);
      in_vld = 1'b0; cfg_apply = 1'b0;
      @(negedge clk);
      chk("R1 early valid", int'(out_vld), 0);
      @(negedge clk);
      chk("R1 valid", int'(out_vld), 1);
      chk({tag, " em"}, int'(out_em), e_em);
      chk({tag, " had"}, int'(out_had), e_had);
      chk("R5 sum", int'(out_sum), e_em + e_had);
      chk("R6 electron", int'(out_ele), ref_ele(e_em, e_had, fg));
   endtask

   task automatic t_reset();
      chk("R11 vld", int'(out_vld), 0);
      chk("R11 em", int'(out_em), 0);
      chk("R11 had", int'(out_had), 0);
      chk("R11 sum", int'(out_sum), 0);
      chk("R11 ele", int'(out_ele), 0);
      send(8'h25, 0, 0, 1'b0, "R11 reset set");   // shift mode, ratio 0
   endtask

   task automatic t_shift();
      send(8'hFF, 8'h00, 0, 1'b0, "R2 max");
      send(8'h1F, 8'hE1, 0, 1'b0, "R2 mix");
      send(8'h6A, 8'h3C, 1, 1'b0, "R2 mid");
   endtask

   task automatic t_segment();
      int ke[3] = '{40, 100, 200};
      int kh[3] = '{16, 64, 128};
      int se[4] = '{16, 40, 8, 255};
      int sh[4] = '{32, 24, 200, 255};
      int be[4] = '{5, 100, 300, 60000};
      int bh[4] = '{0, 500, 2000, 65500};
      for (int i = 0; i < 3; i++) begin wr(i, ke[i]); wr(16 + i, kh[i]); end
      for (int i = 0; i < 4; i++) begin
         wr(3 + i, se[i]); wr(19 + i, sh[i]);
         wr(7 + i, be[i]); wr(23 + i, bh[i]);
      end
      wr(15, (4 << 1) | 1);                          // R9 segment mode, ratio 4
      apply();
      send(0, 0, 0, 1'b0, "R3 zero");
      send(39, 15, 0, 1'b0, "R3 below knee0");
      send(40, 16, 0, 1'b0, "R3 at knee0");
      send(99, 63, 0, 1'b0, "R4 seg1 top");
      send(100, 64, 0, 1'b0, "R3 at knee1");
      send(199, 127, 0, 1'b0, "R4 seg2 top");
      send(200, 128, 0, 1'b0, "R3 at knee2");
      send(255, 255, 0, 1'b0, "R4 saturate");
   endtask

   task automatic t_cut();
      wr(15, (2 << 1) | 0);                          // shift mode, ratio 2
      apply();
      send(8'hA1, 8'h08, 0, 1'b0, "R6 equal");       // 64 <= 64
      send(8'hA1, 8'h09, 0, 1'b0, "R6 above");       // 72 > 64
      send(8'hA1, 8'h01, 1, 1'b0, "R6 veto");
      wr(15, (7 << 1) | 0);
      apply();
      send(8'h48, 8'h1C, 0, 1'b0, "R6 ratio7");
   endtask

   task automatic t_staging();
      wr(15, (1 << 1) | 1);                          // staged only
      send(8'hA1, 8'h04, 0, 1'b0, "R7 not applied");
      send(8'hA1, 8'h04, 0, 1'b1, "R7 same edge");
   endtask

   task automatic t_unmapped();
      wr(15, (3 << 1) | 1);
      apply();
      wr(11, 16'hFFFF); wr(14, 16'h1234); wr(27, 16'h0F0F);
      wr(31, 16'h0000);                              // would clear mode if decoded
      apply();
      send(150, 90, 0, 1'b0, "R10 unmapped");
      chk("R10 mode kept", int'(out_em), ref_lin(0, 150));
   endtask

   task automatic t_stream();
      int em[8] = '{3, 47, 101, 250, 0, 199, 200, 77};
      int hd[8] = '{9, 12, 180, 2, 255, 64, 40, 1};
      int fg[8] = '{0, 1, 0, 0, 0, 1, 0, 0};
      int ee, eh;
      for (int j = 0; j < 11; j++) begin
         @(negedge clk);
         if (j >= 3) begin
            ee = ref_lin(0, em[j-3]); eh = ref_lin(1, hd[j-3]);
            chk("R1 stream valid", int'(out_vld), 1);
            chk("R4 stream em", int'(out_em), ee);
            chk("R4 stream had", int'(out_had), eh);
            chk("R5 stream sum", int'(out_sum), ee + eh);
            chk("R6 stream ele", int'(out_ele), ref_ele(ee, eh, fg[j-3]));
         end
         if (j < 8) begin
            in_vld = 1'b1; in_em_code = 8'(em[j]); in_had_code = 8'(hd[j]);
            in_fg = fg[j][0];
         end else begin
            in_vld = 1'b0;
         end
      end
      @(negedge clk);
      chk("R1 stream drained", int'(out_vld), 0);
   endtask

   initial begin
      rst = 1'b1; in_vld = 1'b0; in_em_code = '0; in_had_code = '0; in_fg = 1'b0;
      cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_apply = 1'b0;
      g_knee = '{default: '{default: 0}}; g_slope = '{default: '{default: 0}};
      g_base = '{default: '{default: 0}}; g_seg = 0; g_ratio = 0;
      model_apply();
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_shift();
      t_segment();
      t_stream();
      t_cut();
      t_staging();
      t_unmapped();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule